// File: doc/BRIEF.md
# Dual-Accumulator Execute Unit

This block is the execute datapath of a small 12-bit processor. It keeps two accumulators, a primary and a secondary, which also act as one 24-bit pair with the secondary as the upper half. Each cycle it may receive one decoded operation with an operand whose addressing has already been resolved. From these it performs loads, arithmetic, logic, compares, single and paired shifts, single-bit input reads and one step of a shift-and-add multiply. After each operation it refreshes a set of condition flags that a separate branch unit reads.

The primary accumulator is the default target. A one-cycle strobe on `sel_b` arms a selection that sends the next accumulator operation to the secondary accumulator. That operation uses the selection up, and the target then falls back to the primary. The minus flag does not follow the newest result. It follows a short chain that moves forward once per accumulator operation, so it reports the sign of an earlier result.

Top module: `dacc_exec`

## Requirements
- R1: A cycle with `sel_b` high arms a pending secondary selection. The next accepted operation (codes 0 to 12) then uses accumulator B, and the selection clears unless `sel_b` is high in that same cycle. Idle cycles keep the selection. An operation without a pending selection leaves B unchanged, except for codes 10, 11 and 12, which always act on the pair.
- R2: Code 0 loads the operand. Code 1 puts operand bits 3:0 into bits 11:8 and clears bits 7:0. Code 2 puts `in_bits[operand[3:0]]` into bit 0 and clears bits 11:1.
- R3: Code 3 adds the operand, code 4 subtracts it, code 5 ANDs it with the accumulator, and code 6 compares. A compare changes neither accumulator.
- R4: Subtract is computed as accumulator + ~operand + 1. After code 3, NC is 1 when the 12-bit add has no carry out. After every other accepted code, NC is 1 when the subtract sum has no carry out, so 0 minus 1 gives 0xFFF with NC = 1.
- R5: On every accepted operation, LT is set to (operand < old accumulator, unsigned) and EQ to (operand == old accumulator), using the selected accumulator.
- R6: On every accepted operation, A0 takes A bit 0 as it was before the operation, whichever accumulator is selected.
- R7: After an accepted operation, MI equals bit 11 that the selected accumulator held after the accepted operation before it.
- R8: Code 7 shifts right, filling with zero on A and with the sign on B. Code 8 shifts right and fills with the sign on either accumulator. Code 9 shifts left with a zero fill.
- R9: Code 10 shifts the pair right: B fills with its sign, and B bit 0 enters A bit 11. Code 11 shifts both halves left with a zero fill, and A bit 11 is lost.
- R10: Code 12 forms B + (A[0] ? operand : 0) as a 13-bit sum, then shifts {sum, A} right by one. Twelve steps leave A*operand + initial B in {B, A}.
- R11: Codes 13 to 15, and cycles with `op_valid` low, change no accumulator, no flag and no pending selection.
- R12: Synchronous active-high reset clears both accumulators, the pending selection, every flag and the minus-flag chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 4 | Decoded operation code (0 to 12 defined) |
| operand | input | 12 | Resolved operand |
| sel_b | input | 1 | Arms the secondary selection for the next operation |
| in_bits | input | 16 | Input lines read by code 2 |
| acc_a | output | 12 | Primary accumulator (low half of the pair) |
| acc_b | output | 12 | Secondary accumulator (high half of the pair) |
| flg_mi | output | 1 | Delayed minus flag |
| flg_lt | output | 1 | Operand below accumulator |
| flg_eq | output | 1 | Operand equal to accumulator |
| flg_nc | output | 1 | No carry from the last sum |
| flg_a0 | output | 1 | Prior A bit 0 |

## Verification
The bench builds the unit with its defaults: a 12-bit word, 16 input lines, a two-step minus chain and a 4-bit short immediate. With these values the sign bit and the carry boundary sit exactly at 0x800 and 0xFFF. A full twelve-step multiply then lands on known 24-bit products, including the all-ones case where the initial B value fills the product up to 0xFFF000. Every input index can be selected through the operand's low nibble, and the two-step chain shows MI lagging the newest sign by one accepted operation.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,  OP_LDHI = 4'd1,  OP_INP  = 4'd2,  OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,  OP_AND  = 4'd5,  OP_CMP  = 4'd6,  OP_LSR  = 4'd7,
    OP_ASR  = 4'd8,  OP_LSL  = 4'd9,  OP_ASRD = 4'd10, OP_LSLD = 4'd11,
    OP_MUL  = 4'd12
  } op_e;

  localparam logic [3:0] OP_LAST = 4'd12;

  function automatic logic op_known(input logic [3:0] c);
    return c <= OP_LAST;
  endfunction
endpackage

// File: rtl/dacc_arith.sv
module dacc_arith #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] add_sum,
  output logic         add_co,
  output logic [W-1:0] sub_sum,
  output logic         sub_co,
  output logic         lt,
  output logic         eq
);
  logic [W:0] s_add, s_sub;

  always_comb begin
    s_add = {1'b0, acc} + {1'b0, opnd};
    s_sub = {1'b0, acc} + {1'b0, ~opnd} + (W+1)'(1);
    add_sum = s_add[W-1:0];
    add_co  = s_add[W];
    sub_sum = s_sub[W-1:0];
    sub_co  = s_sub[W];
    lt      = opnd < acc;
    eq      = opnd == acc;
  end
endmodule

// File: rtl/dacc_shift.sv
module dacc_shift #(
  parameter int W = 12
) (
  input  logic [3:0]   code,
  input  logic         use_b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] na,
  output logic [W-1:0] nb
);
  import dacc_pkg::*;

  logic [W-1:0] cur, single;
  logic         rfill;

  always_comb begin
    cur    = use_b ? b : a;
    rfill  = 1'b0;
    single = cur;
    case (code)
      OP_LSR: begin
        rfill  = use_b ? cur[W-1] : 1'b0;
        single = {rfill, cur[W-1:1]};
      end
      OP_ASR: single = {cur[W-1], cur[W-1:1]};
      OP_LSL: single = {cur[W-2:0], 1'b0};
      default: single = cur;
    endcase

    na = a;
    nb = b;
    case (code)
      OP_ASRD: begin
        nb = {b[W-1], b[W-1:1]};
        na = {b[0], a[W-1:1]};
      end
      OP_LSLD: begin
        nb = {b[W-2:0], 1'b0};
        na = {a[W-2:0], 1'b0};
      end
      default: begin
        if (use_b) nb = single;
        else       na = single;
      end
    endcase
  end
endmodule

// File: rtl/dacc_mstep.sv
module dacc_mstep #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] na,
  output logic [W-1:0] nb
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, b} + (a[0] ? {1'b0, opnd} : '0);
    nb  = sum[W:1];
    na  = {sum[0], a[W-1:1]};
  end
endmodule

// File: rtl/dacc_mipipe.sv
module dacc_mipipe #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic mi
);
  logic [LAG-1:0] chain;

  generate
    if (LAG == 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst)      chain <= '0;
        else if (adv) chain <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)      chain <= '0;
        else if (adv) chain <= {chain[LAG-2:0], din};
      end
    end
  endgenerate

  assign mi = chain[LAG-1];
endmodule

// File: rtl/dacc_exec.sv
module dacc_exec #(
  parameter int W       = 12,
  parameter int NIN     = 16,
  parameter int MI_LAG  = 2,
  parameter int SHORT_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [W-1:0]   operand,
  input  logic           sel_b,
  input  logic [NIN-1:0] in_bits,
  output logic [W-1:0]   acc_a,
  output logic [W-1:0]   acc_b,
  output logic           flg_mi,
  output logic           flg_lt,
  output logic           flg_eq,
  output logic           flg_nc,
  output logic           flg_a0
);
  import dacc_pkg::*;

  localparam int IDXW = (NIN > 1) ? $clog2(NIN) : 1;
  localparam int LOW_W = W - SHORT_W;

  logic           pend_b;
  logic           act;
  logic [W-1:0]   cur;
  logic [W-1:0]   add_sum, sub_sum;
  logic           add_co, sub_co, lt_w, eq_w;
  logic [W-1:0]   sh_a, sh_b, mu_a, mu_b;
  logic [W-1:0]   res, na, nb, nsel;
  logic [IDXW-1:0] idx;
  logic           in_bit;
  op_e            code;

  assign code = op_e'(op_code);
  assign act  = op_valid && op_known(op_code);
  assign cur  = pend_b ? acc_b : acc_a;
  assign idx  = operand[IDXW-1:0];
  assign in_bit = (32'(idx) < NIN) ? in_bits[idx] : 1'b0;

  dacc_arith #(.W(W)) u_arith (
    .acc(cur), .opnd(operand),
    .add_sum(add_sum), .add_co(add_co),
    .sub_sum(sub_sum), .sub_co(sub_co),
    .lt(lt_w), .eq(eq_w)
  );

  dacc_shift #(.W(W)) u_shift (
    .code(op_code), .use_b(pend_b), .a(acc_a), .b(acc_b),
    .na(sh_a), .nb(sh_b)
  );

  dacc_mstep #(.W(W)) u_mstep (
    .a(acc_a), .b(acc_b), .opnd(operand), .na(mu_a), .nb(mu_b)
  );

  always_comb begin
    case (code)
      OP_LOAD: res = operand;
      OP_LDHI: res = {operand[SHORT_W-1:0], {LOW_W{1'b0}}};
      OP_INP:  res = {{(W-1){1'b0}}, in_bit};
      OP_ADD:  res = add_sum;
      OP_SUB:  res = sub_sum;
      OP_AND:  res = cur & operand;
      default: res = cur;
    endcase

    na = acc_a;
    nb = acc_b;
    case (code)
      OP_LSR, OP_ASR, OP_LSL, OP_ASRD, OP_LSLD: begin
        na = sh_a;
        nb = sh_b;
      end
      OP_MUL: begin
        na = mu_a;
        nb = mu_b;
      end
      default: begin
        if (pend_b) nb = res;
        else        na = res;
      end
    endcase
    nsel = pend_b ? nb : na;
  end

  dacc_mipipe #(.LAG(MI_LAG)) u_mi (
    .clk(clk), .rst(rst), .adv(act), .din(nsel[W-1]), .mi(flg_mi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a  <= '0;
      acc_b  <= '0;
      pend_b <= 1'b0;
      flg_lt <= 1'b0;
      flg_eq <= 1'b0;
      flg_nc <= 1'b0;
      flg_a0 <= 1'b0;
    end else begin
      pend_b <= sel_b | (pend_b & ~act);
      if (act) begin
        acc_a  <= na;
        acc_b  <= nb;
        flg_lt <= lt_w;
        flg_eq <= eq_w;
        flg_nc <= (code == OP_ADD) ? ~add_co : ~sub_co;
        flg_a0 <= acc_a[0];
      end
    end
  end
endmodule

// File: rtl/dacc_exec_chk.sv
module dacc_exec_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] operand,
  input logic         sel_b,
  input logic         pend_b,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] acc_b,
  input logic         flg_mi,
  input logic         flg_lt,
  input logic         flg_eq,
  input logic         flg_nc,
  input logic         flg_a0
);
  logic known;
  assign known = op_code <= 4'd12;

  AST_PREFIX_SPENT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && known && !sel_b) |=> !pend_b); // R1
  AST_PREFIX_WAITS: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && pend_b) |=> pend_b); // R1
  AST_B_SPARED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 4'd9 && !pend_b) |=> acc_b == $past(acc_b)); // R1
  AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6) |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b))); // R3
  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && known && !pend_b) |=> flg_eq == ($past(operand) == $past(acc_a))); // R5
  AST_A0_PRIOR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && known) |=> flg_a0 == $past(acc_a[0])); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || !known) |=> $stable(acc_a) && $stable(acc_b) && $stable(flg_mi)
      && $stable(flg_lt) && $stable(flg_eq) && $stable(flg_nc) && $stable(flg_a0)); // R11
endmodule

bind dacc_exec dacc_exec_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .operand(operand), .sel_b(sel_b), .pend_b(pend_b),
  .acc_a(acc_a), .acc_b(acc_b), .flg_mi(flg_mi), .flg_lt(flg_lt),
  .flg_eq(flg_eq), .flg_nc(flg_nc), .flg_a0(flg_a0)
);

// File: tb/dacc_exec_test.sv
module dacc_exec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [11:0] operand = 12'd0;
  logic        sel_b = 1'b0;
  logic [15:0] in_bits = 16'h0000;
  logic [11:0] acc_a, acc_b;
  logic        flg_mi, flg_lt, flg_eq, flg_nc, flg_a0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dacc_exec uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .sel_b(sel_b), .in_bits(in_bits),
    .acc_a(acc_a), .acc_b(acc_b), .flg_mi(flg_mi), .flg_lt(flg_lt),
    .flg_eq(flg_eq), .flg_nc(flg_nc), .flg_a0(flg_a0)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] c, input logic [11:0] v);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; operand = v;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic pfx();
    @(negedge clk);
    sel_b = 1'b1;
    @(negedge clk);
    sel_b = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 reset A", acc_a, 0);
    check("R12 reset B", acc_b, 0);
    check("R12 reset flags", {flg_mi, flg_lt, flg_eq, flg_nc, flg_a0}, 0);
  endtask

  task automatic t_loads();
    op(4'd0, 12'h123); check("R2 load", acc_a, 12'h123);
    op(4'd1, 12'hFF7); check("R2 short imm", acc_a, 12'h700);
    in_bits = 16'h0020;
    op(4'd2, 12'h005); check("R2 input set", acc_a, 12'h001);
    op(4'd2, 12'h004); check("R2 input clear", acc_a, 12'h000);
  endtask

  task automatic t_prefix();
    op(4'd0, 12'h000);
    pfx(); op(4'd0, 12'hABC);
    check("R1 prefix to B", acc_b, 12'hABC);
    check("R1 A untouched", acc_a, 12'h000);
    op(4'd0, 12'h111);
    check("R1 back to A", acc_a, 12'h111);
    check("R1 B kept", acc_b, 12'hABC);
    pfx(); repeat (3) @(negedge clk);
    op(4'd0, 12'h222);
    check("R1 prefix held over idle", acc_b, 12'h222);
    pfx(); op(4'd2, 12'h005);
    check("R2 input into B", acc_b, 12'h001);
  endtask

  task automatic t_arith();
    op(4'd0, 12'h000); op(4'd4, 12'h001);
    check("R4 zero minus one", acc_a, 12'hFFF);
    check("R4 NC after 0-1", flg_nc, 1);
    op(4'd3, 12'h001);
    check("R3 add wrap", acc_a, 12'h000);
    check("R4 NC add carry", flg_nc, 0);
    op(4'd0, 12'h005); op(4'd3, 12'h002);
    check("R3 add", acc_a, 12'h007);
    check("R4 NC add no carry", flg_nc, 1);
    op(4'd4, 12'h002);
    check("R3 sub", acc_a, 12'h005);
    check("R4 NC sub carry", flg_nc, 0);
    op(4'd0, 12'hF0F); op(4'd5, 12'h0FF);
    check("R3 and", acc_a, 12'h00F);
  endtask

  task automatic t_compare();
    op(4'd0, 12'h100); op(4'd6, 12'h0FF);
    check("R5 lt below", {flg_lt, flg_eq}, 2'b10);
    check("R3 cmp keeps A", acc_a, 12'h100);
    op(4'd6, 12'h100);
    check("R5 equal", {flg_lt, flg_eq}, 2'b01);
    op(4'd6, 12'h200);
    check("R5 above", {flg_lt, flg_eq}, 2'b00);
    check("R4 NC cmp above", flg_nc, 1);
  endtask

  task automatic t_a0();
    op(4'd0, 12'h001);
    pfx(); op(4'd0, 12'h000);
    check("R6 A0 on B op", flg_a0, 1);
    op(4'd0, 12'h002);
    check("R6 A0 prior one", flg_a0, 1);
    op(4'd0, 12'h003);
    check("R6 A0 prior zero", flg_a0, 0);
  endtask

  task automatic t_mi();
    op(4'd0, 12'h800); op(4'd4, 12'h001);
    check("R7 MI lags set", flg_mi, 1);
    op(4'd6, 12'h000);
    check("R7 MI lags clear", flg_mi, 0);
  endtask

  task automatic t_shift();
    op(4'd0, 12'h802); op(4'd7, 0); check("R8 A lsr", acc_a, 12'h401);
    op(4'd0, 12'h802); op(4'd8, 0); check("R8 A asr", acc_a, 12'hC01);
    op(4'd0, 12'h802); op(4'd9, 0); check("R8 A lsl", acc_a, 12'h004);
    pfx(); op(4'd0, 12'h802); pfx(); op(4'd7, 0);
    check("R8 B lsr sign", acc_b, 12'hC01);
  endtask

  task automatic t_dshift();
    op(4'd0, 12'h002); pfx(); op(4'd0, 12'h801);
    op(4'd10, 0);
    check("R9 asrd B", acc_b, 12'hC00);
    check("R9 asrd A", acc_a, 12'h801);
    op(4'd0, 12'h800); pfx(); op(4'd0, 12'h801);
    op(4'd11, 0);
    check("R9 lsld B", acc_b, 12'h002);
    check("R9 lsld A", acc_a, 12'h000);
  endtask

  task automatic t_mul();
    op(4'd0, 12'h725); pfx(); op(4'd0, 12'h000);
    for (int i = 0; i < 12; i++) op(4'd12, 12'h200);
    check("R10 product", {acc_b, acc_a}, 24'h0E4A00);
    op(4'd0, 12'hFFF); pfx(); op(4'd0, 12'hFFF);
    for (int i = 0; i < 12; i++) op(4'd12, 12'hFFF);
    check("R10 product plus B", {acc_b, acc_a}, 24'hFFF000);
  endtask

  task automatic t_reserved();
    logic [4:0] f;
    op(4'd0, 12'h0A0);
    f = {flg_mi, flg_lt, flg_eq, flg_nc, flg_a0};
    pfx(); op(4'd13, 12'h777);
    check("R11 reserved A", acc_a, 12'h0A0);
    check("R11 reserved flags", {flg_mi, flg_lt, flg_eq, flg_nc, flg_a0}, f);
    op(4'd0, 12'h5A5);
    check("R11 reserved keeps prefix", acc_b, 12'h5A5);
    check("R11 A after prefixed load", acc_a, 12'h0A0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_prefix();
    t_arith();
    t_compare();
    t_a0();
    t_mi();
    t_shift();
    t_dshift();
    t_mul();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule